// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level command engine of a serial NOR flash slave. A bit deserializer in front of it hands over one received byte per transfer and takes back one response byte per transfer. The first byte after chip select goes low is an opcode. Depending on that opcode the engine either acts on it at once, or gathers address, dummy and parameter bytes before it streams array data, accepts program data or starts an erase. Requests to the storage array leave through a simple memory port: a combinational read, a per-byte program strobe and an erase pulse with a size code.

Address width comes from three sources. Some opcodes always use four bytes. Others use four bytes when a sticky wide-address mode is set and three bytes otherwise. In three-byte form, an 8-bit extension register supplies address bits 25:24. The number of dummy bytes on fast reads depends on the manufacturer code, which is set by a parameter.

Top module: `nor_cmd_seq`

## Requirements
- R1: While `cs_n` is high the engine returns to idle and clears its byte counters. The first transfer after `cs_n` goes low is decoded as an opcode, even if the previous frame ended part way through an address.
- R2: Opcode 0x06 sets write enable and 0x04 clears it. Opcode 0x05 replies with one byte that has write enable in bit 1 and zeros elsewhere.
- R3: Opcode 0xB7 sets the sticky wide-address mode and 0xE9 clears it. Opcode 0x70 replies with one byte: bit 7 is 1 (ready), bit 0 is the sticky mode, and all other bits are 0.
- R4: Opcode 0x9F replies with `MFR_ID`, `DEV_ID[15:8]` and `DEV_ID[7:0]`. When `EXT_ID` is nonzero it then also replies with `EXT_ID[15:8]` and `EXT_ID[7:0]`. After the last reply byte, the next transfer is decoded as an opcode.
- R5: Address bytes are taken most significant first. Opcodes 0x13, 0x0C, 0x3C, 0x6C, 0xBC, 0xEC, 0x12, 0x21 and 0xDC always take 4 bytes. Other addressed opcodes take 4 bytes when sticky mode is set; otherwise they take 3 bytes, with extension register bits 1:0 placed at address bits 25:24.
- R6: After the address of a read opcode (0x03, 0x13, 0x0B, 0x0C, 0x3B, 0x3C, 0x6B, 0x6C, 0xBB, 0xBC, 0xEB, 0xEC), each transfer returns the array byte at the current address on `tx_byte` in the next cycle. The address then increments modulo 2^`ADDR_W`. Every other response byte is 0x00.
- R7: When `MFR_ID` is 0x20, reads 0x0B, 0x0C, 0x3B, 0x3C, 0x6B and 0x6C collect extra dummy bytes equal to volatile config bits 7:4. For any other manufacturer they collect none.
- R8: When `MFR_ID` is 0xEF or 0x01, opcodes 0xBB/0xBC collect exactly 4 bytes and 0xEB/0xEC exactly 6 bytes, with the address taken from the leading bytes. For any other manufacturer they collect the address bytes plus volatile config bits 7:4.
- R9: After the address of 0x02, 0x12, 0xA2 or 0x32, each transfer raises `mem_wr_en` with `mem_wr_data` equal to the byte and `mem_addr` equal to the current address. The address then increments.
- R10: Erase opcodes 0x20/0x21 (kind 0), 0x52 (kind 1) and 0xD8/0xDC (kind 2) raise `mem_erase_en` for one cycle, in the cycle after the last address byte, with the assembled address on `mem_addr`. This happens only when write enable is set.
- R11: Register writes 0x01 (status), 0xC5 (extension) and 0x81 (volatile config) take one byte, and only when write enable is set. Without it the opcode is dropped and the next byte is decoded as an opcode. A completed status write clears write enable. Opcodes 0xC8 and 0x85 read back the extension register and the volatile config.
- R12: An unknown opcode leaves the engine idle, and the next byte is decoded as an opcode.
- R13: After reset `tx_valid`, `tx_byte` and `mem_erase_en` are 0, write enable, sticky mode and extension register are 0, and volatile config equals `VCFG_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high frames the engine back to idle |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Response byte valid, one cycle after each transfer |
| tx_byte | output | 8 | Response byte for the last transfer |
| mem_addr | output | ADDR_W | Current array address |
| mem_rd_en | output | 1 | Array read during a read-state transfer |
| mem_rd_data | input | 8 | Array byte at `mem_addr`, combinational |
| mem_wr_en | output | 1 | Program strobe for one byte |
| mem_wr_data | output | 8 | Byte to program |
| mem_erase_en | output | 1 | One-cycle erase request at `mem_addr` |
| mem_erase_kind | output | 2 | Erase size: 0 small, 1 medium, 2 sector |

## Verification
The assertions assume that `rx_valid` never appears while `cs_n` is high. They also assume that `cs_n` is held high through reset, so that the first sampled frame starts from idle. The address-step properties rely on `mem_addr` moving only on accepted transfers. The stimulus drives every byte as a single-cycle strobe followed by a quiet cycle, changes `cs_n` only between transfers, and keeps it high until reset is released.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int          ADDR_W    = 26,
  parameter int          CNT_W     = 5,
  parameter logic [7:0]  MFR_ID    = 8'h20,
  parameter logic [15:0] DEV_ID    = 16'hBA19,
  parameter logic [15:0] EXT_ID    = 16'h0000,
  parameter logic [7:0]  VCFG_INIT = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wr_data,
  output logic              mem_erase_en,
  output logic [1:0]        mem_erase_kind
);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_READ, S_COLL, S_REPLY} st_t;

  localparam logic FIXED_IO = (MFR_ID == 8'hEF) || (MFR_ID == 8'h01);
  localparam logic HAS_DUMMY = (MFR_ID == 8'h20);
  localparam logic [2:0] ID_LEN = (EXT_ID != 16'h0000) ? 3'd5 : 3'd3;

  function automatic logic op_wide(input logic [7:0] op);
    return op inside {8'h13, 8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC, 8'h12, 8'h21, 8'hDC};
  endfunction
  function automatic logic op_fast(input logic [7:0] op);
    return op inside {8'h0B, 8'h0C, 8'h3B, 8'h3C, 8'h6B, 8'h6C};
  endfunction
  function automatic logic op_dio(input logic [7:0] op);
    return op inside {8'hBB, 8'hBC};
  endfunction
  function automatic logic op_qio(input logic [7:0] op);
    return op inside {8'hEB, 8'hEC};
  endfunction
  function automatic logic op_read(input logic [7:0] op);
    return (op inside {8'h03, 8'h13}) || op_fast(op) || op_dio(op) || op_qio(op);
  endfunction
  function automatic logic op_prog(input logic [7:0] op);
    return op inside {8'h02, 8'h12, 8'hA2, 8'h32};
  endfunction
  function automatic logic op_erase(input logic [7:0] op);
    return op inside {8'h20, 8'h21, 8'h52, 8'hD8, 8'hDC};
  endfunction
  function automatic logic [31:0] join_addr(input logic w4, input logic [7:0] e,
                                            input logic [7:0] b0, input logic [7:0] b1,
                                            input logic [7:0] b2, input logic [7:0] b3);
    return w4 ? {b0, b1, b2, b3} : {6'd0, e[1:0], b0, b1, b2};
  endfunction

  st_t               st;
  logic [7:0]        cmd_q;
  logic              wide_q;
  logic [CNT_W-1:0]  need_q, cnt_q;
  logic [2:0]        pos_q, rlen_q;
  logic [7:0]        abuf [4];
  logic [7:0]        bn   [4];
  logic              we_q, four_q;
  logic [7:0]        ext_q, vcfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              in_idle;

  wire go = rx_valid & ~cs_n;
  wire wide_n = op_wide(rx_byte) | four_q;
  wire [CNT_W-1:0] alen_n = wide_n ? CNT_W'(4) : CNT_W'(3);
  wire [CNT_W-1:0] dummy  = CNT_W'(vcfg_q[7:4]);
  wire last = (cnt_q + CNT_W'(1)) == need_q;

  logic [CNT_W-1:0] need_n;
  always_comb begin
    if (op_dio(rx_byte))       need_n = FIXED_IO ? CNT_W'(4) : alen_n + dummy;
    else if (op_qio(rx_byte))  need_n = FIXED_IO ? CNT_W'(6) : alen_n + dummy;
    else if (op_fast(rx_byte)) need_n = HAS_DUMMY ? alen_n + dummy : alen_n;
    else                       need_n = alen_n;
  end

  always_comb begin
    bn = abuf;
    if (cnt_q < CNT_W'(4)) bn[cnt_q[1:0]] = rx_byte;
  end

  wire [ADDR_W-1:0] addr_n = ADDR_W'(join_addr(wide_q, ext_q, bn[0], bn[1], bn[2], bn[3]));

  logic [7:0] reply;
  always_comb begin
    unique case (cmd_q)
      8'h05:   reply = {6'd0, we_q, 1'b0};
      8'h70:   reply = {1'b1, 6'd0, four_q};
      8'hC8:   reply = ext_q;
      8'h85:   reply = vcfg_q;
      default: case (pos_q)
                 3'd0:    reply = MFR_ID;
                 3'd1:    reply = DEV_ID[15:8];
                 3'd2:    reply = DEV_ID[7:0];
                 3'd3:    reply = EXT_ID[15:8];
                 default: reply = EXT_ID[7:0];
               endcase
    endcase
  end

  assign mem_addr    = addr_q;
  assign mem_rd_en   = go && (st == S_READ);
  assign mem_wr_en   = go && (st == S_PROG);
  assign mem_wr_data = rx_byte;
  assign in_idle     = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd_q <= 8'h00;
      wide_q <= 1'b0;
      need_q <= '0;
      cnt_q <= '0;
      pos_q <= '0;
      rlen_q <= '0;
      abuf <= '{default: 8'h00};
      we_q <= 1'b0;
      four_q <= 1'b0;
      ext_q <= 8'h00;
      vcfg_q <= VCFG_INIT;
      addr_q <= '0;
      tx_valid <= 1'b0;
      tx_byte <= 8'h00;
      mem_erase_en <= 1'b0;
      mem_erase_kind <= 2'd0;
    end else begin
      tx_valid <= go;
      mem_erase_en <= 1'b0;
      if (cs_n) begin
        st <= S_IDLE;
        cnt_q <= '0;
        pos_q <= '0;
      end else if (rx_valid) begin
        tx_byte <= 8'h00;
        unique case (st)
          S_IDLE: begin
            cmd_q <= rx_byte;
            wide_q <= wide_n;
            cnt_q <= '0;
            pos_q <= '0;
            if (op_read(rx_byte) || op_prog(rx_byte) || op_erase(rx_byte)) begin
              need_q <= need_n;
              st <= S_COLL;
            end else begin
              case (rx_byte)
                8'h06: we_q <= 1'b1;
                8'h04: we_q <= 1'b0;
                8'hB7: four_q <= 1'b1;
                8'hE9: four_q <= 1'b0;
                8'h01, 8'hC5, 8'h81:
                  if (we_q) begin
                    need_q <= CNT_W'(1);
                    st <= S_COLL;
                  end
                8'h05, 8'h70, 8'hC8, 8'h85: begin
                  rlen_q <= 3'd1;
                  st <= S_REPLY;
                end
                8'h9F: begin
                  rlen_q <= ID_LEN;
                  st <= S_REPLY;
                end
                default: ;
              endcase
            end
          end
          S_PROG: addr_q <= addr_q + ADDR_W'(1);
          S_READ: begin
            tx_byte <= mem_rd_data;
            addr_q <= addr_q + ADDR_W'(1);
          end
          S_COLL: begin
            abuf <= bn;
            cnt_q <= cnt_q + CNT_W'(1);
            if (last) begin
              st <= S_IDLE;
              addr_q <= addr_n;
              if (op_prog(cmd_q)) st <= S_PROG;
              if (op_read(cmd_q)) st <= S_READ;
              if (op_erase(cmd_q)) begin
                mem_erase_en <= we_q;
                mem_erase_kind <= (cmd_q inside {8'h20, 8'h21}) ? 2'd0 :
                                  (cmd_q == 8'h52) ? 2'd1 : 2'd2;
              end
              case (cmd_q)
                8'h01: we_q <= 1'b0;
                8'hC5: ext_q <= bn[0];
                8'h81: vcfg_q <= bn[0];
                default: ;
              endcase
            end
          end
          S_REPLY: begin
            tx_byte <= reply;
            if (pos_q + 3'd1 == rlen_q) begin
              st <= S_IDLE;
              pos_q <= '0;
            end else begin
              pos_q <= pos_q + 3'd1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              mem_erase_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              we,
  input logic              idle
);

  // R1
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> idle);

  // R6
  tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(rx_valid && !cs_n));

  // R6
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

  // R9
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

  // R10
  erase_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_erase_en |-> $past(we));

  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_en, mem_wr_en, mem_erase_en}));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
  .tx_valid(tx_valid), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .mem_erase_en(mem_erase_en), .mem_addr(mem_addr), .we(we_q), .idle(in_idle)
);

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/100ps
module nor_cmd_seq_test;
  localparam int AW = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;

  logic tx_valid, tx_valid2;
  logic [7:0] tx_byte, tx_byte2;
  logic [AW-1:0] mem_addr, mem_addr2;
  logic rd_en, rd_en2, wr_en, wr_en2, er_en, er_en2;
  logic [7:0] wr_data, wr_data2, rd_data, rd_data2;
  logic [1:0] er_kind, er_kind2;

  always #2.5 clk = ~clk;

  assign rd_data  = mem_addr[7:0]  + mem_addr[25:18];
  assign rd_data2 = mem_addr2[7:0] + mem_addr2[25:18];

  nor_cmd_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .mem_addr(mem_addr), .mem_rd_en(rd_en),
    .mem_rd_data(rd_data), .mem_wr_en(wr_en), .mem_wr_data(wr_data),
    .mem_erase_en(er_en), .mem_erase_kind(er_kind));

  nor_cmd_seq #(.ADDR_W(AW), .MFR_ID(8'hEF), .DEV_ID(16'h4018), .EXT_ID(16'h4D01)) uut2 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid2), .tx_byte(tx_byte2), .mem_addr(mem_addr2), .mem_rd_en(rd_en2),
    .mem_rd_data(rd_data2), .mem_wr_en(wr_en2), .mem_wr_data(wr_data2),
    .mem_erase_en(er_en2), .mem_erase_kind(er_kind2));

  int nchk = 0;
  int nfail = 0;
  logic [7:0] r1, r2, s_wdata;
  logic s_rd, s_wr, s_er;
  logic [1:0] s_kind;
  logic [AW-1:0] s_addr, s_eaddr;

  function automatic logic [21:0] v(input logic brk, input logic [3:0] req,
                                    input logic [7:0] b, input logic [7:0] e, input logic c);
    return {brk, req, b, e, c};
  endfunction

  localparam int NV = 64;
  localparam logic [21:0] TBL [NV] = '{
    v(1,2,8'h06,8'h00,0), v(1,2,8'h05,8'h00,0), v(0,2,8'h00,8'h02,1),             // R2
    v(1,3,8'h70,8'h00,0), v(0,3,8'h00,8'h80,1),                                  // R3
    v(1,3,8'hB7,8'h00,0), v(1,3,8'h70,8'h00,0), v(0,3,8'h00,8'h81,1),
    v(1,3,8'hE9,8'h00,0),
    v(1,4,8'h9F,8'h00,0), v(0,4,8'h00,8'h20,1), v(0,4,8'h00,8'hBA,1),            // R4
    v(0,4,8'h00,8'h19,1), v(0,4,8'h05,8'h00,1), v(0,4,8'h00,8'h02,1),
    v(1,5,8'h03,8'h00,0), v(0,5,8'h00,8'h00,0), v(0,5,8'h12,8'h00,0),            // R5
    v(0,5,8'h34,8'h00,1), v(0,6,8'h00,8'h34,1),                                  // R6
    v(1,6,8'h13,8'h00,0), v(0,6,8'h03,8'h00,0), v(0,6,8'hFF,8'h00,0),
    v(0,6,8'hFF,8'h00,0), v(0,6,8'hFF,8'h00,0), v(0,6,8'h00,8'hFE,1),
    v(0,6,8'h00,8'h00,1),
    v(1,7,8'h0B,8'h00,0), v(0,7,8'h00,8'h00,0), v(0,7,8'h00,8'h00,0),            // R7
    v(0,7,8'h40,8'h00,0), v(0,7,8'hDD,8'h00,1), v(0,7,8'h00,8'h40,1),
    v(1,5,8'hC5,8'h00,0), v(0,5,8'h02,8'h00,0),                                  // R5 extension
    v(1,5,8'h03,8'h00,0), v(0,5,8'h00,8'h00,0), v(0,5,8'h00,8'h00,0),
    v(0,5,8'h05,8'h00,0), v(0,5,8'h00,8'h85,1),
    v(1,11,8'h01,8'h00,0), v(0,11,8'h00,8'h00,0),                                // R11
    v(1,11,8'h05,8'h00,0), v(0,11,8'h00,8'h00,1),
    v(1,11,8'hC5,8'h00,0), v(0,11,8'h05,8'h00,0), v(0,11,8'h00,8'h00,1),
    v(1,11,8'hC8,8'h00,0), v(0,11,8'h00,8'h02,1),
    v(1,12,8'h06,8'h00,0), v(1,12,8'hAA,8'h00,0), v(0,12,8'h05,8'h00,0),         // R12
    v(0,12,8'h00,8'h02,1),
    v(1,1,8'h03,8'h00,0), v(0,1,8'h00,8'h00,0), v(1,1,8'h05,8'h00,0),            // R1
    v(0,1,8'h00,8'h02,1),
    v(1,5,8'hB7,8'h00,0), v(1,5,8'h03,8'h00,0), v(0,5,8'h00,8'h00,0),            // R5 wide
    v(0,5,8'h00,8'h00,0), v(0,5,8'h12,8'h00,0), v(0,5,8'h34,8'h00,0),
    v(0,5,8'h00,8'h34,1)
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) cs_n = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte = b;
    #1;
    s_rd = rd_en; s_wr = wr_en; s_addr = mem_addr; s_wdata = wr_data;
    @(negedge clk);
    rx_valid = 1'b0;
    r1 = tx_byte; r2 = tx_byte2;
    s_er = er_en; s_kind = er_kind; s_eaddr = mem_addr;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 tx_valid", tx_valid, 0);
    chk("R13 tx_byte", tx_byte, 0);
    chk("R13 erase", er_en, 0);
    frame(); xfer(8'h05); xfer(8'h00); chk("R13 write enable", r1, 8'h00);
    frame(); xfer(8'h70); xfer(8'h00); chk("R13 sticky mode", r1, 8'h80);
    frame(); xfer(8'hC8); xfer(8'h00); chk("R13 extension", r1, 8'h00);
    frame(); xfer(8'h85); xfer(8'h00); chk("R13 volatile config", r1, 8'h13);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] e;
      e = TBL[i];
      if (e[21]) frame();
      xfer(e[16:9]);
      if (e[0]) chk($sformatf("R%0d vector %0d", e[20:17], i), r1, e[8:1]);
    end

    frame(); xfer(8'hE9);
    frame(); xfer(8'h06);
    frame(); xfer(8'hC5); xfer(8'h00);

    // R9 program stream
    frame(); xfer(8'h02); xfer(8'h00); xfer(8'h01); xfer(8'h00);
    xfer(8'hAB);
    chk("R9 strobe", {s_wr, s_rd}, 2'b10);
    chk("R9 addr", s_addr, 26'h100);
    chk("R9 data", s_wdata, 8'hAB);
    xfer(8'hCD);
    chk("R9 next addr", s_addr, 26'h101);
    chk("R9 next data", s_wdata, 8'hCD);

    // R10 erase kinds and gating
    frame(); xfer(8'h20); xfer(8'h00); xfer(8'h10); xfer(8'h00);
    chk("R10 small erase", {s_er, s_kind, s_eaddr}, {1'b1, 2'd0, 26'h0001000});
    frame(); xfer(8'h52); xfer(8'h00); xfer(8'h80); xfer(8'h00);
    chk("R10 medium erase", {s_er, s_kind, s_eaddr}, {1'b1, 2'd1, 26'h0008000});
    frame(); xfer(8'hDC); xfer(8'h01); xfer(8'h02); xfer(8'h03); xfer(8'h04);
    chk("R10 sector erase wide", {s_er, s_kind, s_eaddr}, {1'b1, 2'd2, 26'h1020304});
    frame(); xfer(8'h04);
    frame(); xfer(8'hD8); xfer(8'h00); xfer(8'h20); xfer(8'h00);
    chk("R10 erase without write enable", s_er, 1'b0);

    // R11 volatile config write, then R7 dummy count follows it
    frame(); xfer(8'h06);
    frame(); xfer(8'h81); xfer(8'h23);
    frame(); xfer(8'h85); xfer(8'h00); chk("R11 volatile config", r1, 8'h23);
    frame(); xfer(8'h0B); xfer(8'h00); xfer(8'h00); xfer(8'h41); xfer(8'hD0);
    xfer(8'hD1); chk("R7 second dummy", r1, 8'h00);
    xfer(8'h00); chk("R7 data after two dummies", r1, 8'h41);

    // R8 dual I/O on the 0x20 part: address plus two dummies
    frame(); xfer(8'hBB); xfer(8'h00); xfer(8'h00); xfer(8'h50); xfer(8'hFF); xfer(8'hFF);
    xfer(8'h00); chk("R8 dual io with dummies", r1, 8'h50);

    // R4 five-byte identity on second part
    frame(); xfer(8'h9F);
    xfer(8'h00); chk("R4 ext id byte0", r2, 8'hEF);
    xfer(8'h00); chk("R4 ext id byte1", r2, 8'h40);
    xfer(8'h00); chk("R4 ext id byte2", r2, 8'h18);
    xfer(8'h00); chk("R4 ext id byte3", r2, 8'h4D);
    xfer(8'h00); chk("R4 ext id byte4", r2, 8'h01);

    // R8 fixed counts on second part
    frame(); xfer(8'hBB); xfer(8'h00); xfer(8'h00); xfer(8'h50); xfer(8'hFF);
    xfer(8'h00); chk("R8 dual io fixed four", r2, 8'h50);
    frame(); xfer(8'hEB); xfer(8'h00); xfer(8'h00); xfer(8'h60); xfer(8'hFF); xfer(8'hFF);
    xfer(8'hFF); chk("R8 quad io sixth byte", r2, 8'h00);
    xfer(8'h00); chk("R8 quad io fixed six", r2, 8'h60);

    // R7 no dummy bytes on another manufacturer
    frame(); xfer(8'h0B); xfer(8'h00); xfer(8'h00); xfer(8'h41);
    xfer(8'h00); chk("R7 no dummy", r2, 8'h41);

    frame();
    finish_run();
  end
endmodule